// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block keeps the reservations that hardware contexts place with load-locked reads. It uses them to decide whether a store-conditional may write memory. Any store that reaches a reserved 64-byte granule breaks every reservation on that granule. Each context whose reservation is broken by a write from another context gets a one-cycle clear pulse.

Requests arrive as a single-cycle strobe. Each strobe carries a context number, a physical address and an operation code. The block resolves each request in one cycle. Its verdict appears on registered outputs in the cycle after the strobe. The reservation table holds a fixed number of entries, with at most one entry per context.

Top module: `resv_monitor`

## Requirements
- R1: Only the granule number, which is the address with its low 6 bits dropped, is stored and compared. Two addresses that differ only in bits 5:0 refer to the same reservation.
- R2: A load-locked (req_op = 1) from a context that already holds an entry replaces that entry's granule. A later store-conditional to the old granule then fails.
- R3: A load-locked from a context with no entry takes a free entry.
- R4: A plain store (req_op = 3) always gives store_ok = 1 and sc_pass = 0.
- R5: A store-conditional (req_op = 2) succeeds only when an entry holds both the requesting context and the addressed granule. On success both store_ok and sc_pass are 1.
- R6: A failed store-conditional gives store_ok = 0 and sc_pass = 0, and it removes no entry.
- R7: A successful store-conditional or any plain store removes every entry on the written granule, whichever context owns it.
- R8: For each entry removed under R7 whose owner is not the writer, bit <owner> of clr_excl is high for one cycle. The writer's own bit stays low.
- R9: All outputs are registered and belong to the request strobed one cycle earlier. With no strobe, all outputs are 0. A load-locked gives store_ok = 0, sc_pass = 0 and clr_excl = 0.
- R10: A load-locked that needs a new entry while the table is full raises alloc_full for one cycle and changes no entry.
- R11: Several contexts can reserve the same granule at once. A store-conditional still finds its own entry among the entries of other contexts.
- R12: After reset the table is empty and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Request strobe |
| req_ctx | input | CTX_W | Requesting context |
| req_addr | input | ADDR_W | Physical byte address |
| req_op | input | 2 | 0 idle, 1 load-locked, 2 store-conditional, 3 plain store |
| store_ok | output | 1 | Write may proceed |
| sc_pass | output | 1 | Store-conditional outcome, 1 for success |
| clr_excl | output | N_CTX | Per-context notice that a reservation was destroyed |
| alloc_full | output | 1 | Load-locked could not get an entry |

## Verification
The assertions check the per-cycle output relations on every cycle:
- a pass always implies store_ok;
- plain stores are always allowed;
- load-locked and idle cycles produce no write verdict;
- the writer never clears itself;
- alloc_full only follows a load-locked.

Only the bench's scenarios can show that the table contents are right. These are overwrite, allocation, wiping across contexts, untouched entries after a failed conditional, and the full case. The bench compares every response against a per-context reference model.

// File: rtl/resv_pkg.sv
package resv_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_LL   = 2'd1,
    OP_SC   = 2'd2,
    OP_ST   = 2'd3
  } resv_op_e;
endpackage

// File: rtl/resv_slot.sv
// One reservation entry: valid flag plus owner and granule.
module resv_slot #(
  parameter int CTX_W  = 2,
  parameter int GRAN_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [CTX_W-1:0]  ctx_i,
  input  logic [GRAN_W-1:0] gran_i,
  output logic              vld_o,
  output logic [CTX_W-1:0]  ctx_o,
  output logic [GRAN_W-1:0] gran_o
);
  logic vld_d;

  always_comb begin
    vld_d = vld_o;
    if (set_i)      vld_d = 1'b1;
    else if (clr_i) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_o <= 1'b0;
    else        vld_o <= vld_d;
  end

  // payload is qualified by vld_o, so it needs no reset
  always_ff @(posedge clk) begin
    if (set_i) begin
      ctx_o  <= ctx_i;
      gran_o <= gran_i;
    end
  end
endmodule

// File: rtl/resv_pick.sv
// Lowest-index free entry as a one-hot vector.
module resv_pick #(
  parameter int N_ENT = 4
) (
  input  logic [N_ENT-1:0] busy_i,
  output logic [N_ENT-1:0] free_oh_o,
  output logic             any_free_o
);
  always_comb begin
    free_oh_o = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (!busy_i[i]) free_oh_o = N_ENT'(1) << i;
    end
  end
  assign any_free_o = ~&busy_i;
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor #(
  parameter int N_CTX   = 4,
  parameter int N_ENT   = 4,
  parameter int ADDR_W  = 32,
  parameter int GRAN_LG = 6,
  localparam int CTX_W  = (N_CTX > 1) ? $clog2(N_CTX) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic [CTX_W-1:0]  req_ctx,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_op,
  output logic              store_ok,
  output logic              sc_pass,
  output logic [N_CTX-1:0]  clr_excl,
  output logic              alloc_full
);
  import resv_pkg::*;
  localparam int GRAN_W = ADDR_W - GRAN_LG;

  logic [GRAN_W-1:0] req_gran;
  logic [N_ENT-1:0]  e_vld, e_set, e_clr, ctx_hit, addr_hit, free_oh;
  logic              any_free;
  logic [CTX_W-1:0]  e_ctx  [N_ENT];
  logic [GRAN_W-1:0] e_gran [N_ENT];
  logic              ok_d, pass_d, full_d;
  logic [N_CTX-1:0]  clr_d;
  resv_op_e          op;

  assign req_gran = req_addr[ADDR_W-1:GRAN_LG];
  assign op       = resv_op_e'(req_op);

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    resv_slot #(.CTX_W(CTX_W), .GRAN_W(GRAN_W)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (e_set[g]),
      .clr_i  (e_clr[g]),
      .ctx_i  (req_ctx),
      .gran_i (req_gran),
      .vld_o  (e_vld[g]),
      .ctx_o  (e_ctx[g]),
      .gran_o (e_gran[g])
    );
    assign ctx_hit[g]  = e_vld[g] && (e_ctx[g] == req_ctx);
    assign addr_hit[g] = e_vld[g] && (e_gran[g] == req_gran);
  end

  resv_pick #(.N_ENT(N_ENT)) u_pick (
    .busy_i     (e_vld),
    .free_oh_o  (free_oh),
    .any_free_o (any_free)
  );

  // next-state decode
  always_comb begin
    e_set  = '0;
    e_clr  = '0;
    ok_d   = 1'b0;
    pass_d = 1'b0;
    full_d = 1'b0;
    clr_d  = '0;
    if (req_vld) begin
      case (op)
        OP_LL: begin
          if (|ctx_hit)      e_set = ctx_hit;
          else if (any_free) e_set = free_oh;
          else               full_d = 1'b1;
        end
        OP_SC: begin
          if (|(ctx_hit & addr_hit)) begin
            ok_d   = 1'b1;
            pass_d = 1'b1;
            e_clr  = addr_hit;
          end
        end
        OP_ST: begin
          ok_d  = 1'b1;
          e_clr = addr_hit;
        end
        default: ;
      endcase
    end
    for (int i = 0; i < N_ENT; i++) begin
      if (e_clr[i] && (e_ctx[i] != req_ctx)) clr_d[e_ctx[i]] = 1'b1;
    end
  end

  // registered verdict
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_ok   <= 1'b0;
      sc_pass    <= 1'b0;
      clr_excl   <= '0;
      alloc_full <= 1'b0;
    end else begin
      store_ok   <= ok_d;
      sc_pass    <= pass_d;
      clr_excl   <= clr_d;
      alloc_full <= full_d;
    end
  end
endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
  parameter int N_CTX = 4,
  parameter int CTX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_vld,
  input logic [CTX_W-1:0] req_ctx,
  input logic [1:0]       req_op,
  input logic             store_ok,
  input logic             sc_pass,
  input logic [N_CTX-1:0] clr_excl,
  input logic             alloc_full
);
  p_pass_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sc_pass |-> store_ok);

  p_plain_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_op == 2'd3) |=> (store_ok && !sc_pass));

  p_fail_sc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_op == 2'd2) |=> (store_ok == sc_pass));

  p_ll_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_op == 2'd1) |=> (!store_ok && !sc_pass && clr_excl == '0));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> (!store_ok && !sc_pass && clr_excl == '0 && !alloc_full));

  p_no_self_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> !clr_excl[$past(req_ctx)]);

  p_full_after_ll_r10: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_full |-> $past(req_vld && req_op == 2'd1));
endmodule

bind resv_monitor resv_monitor_chk #(.N_CTX(N_CTX), .CTX_W(CTX_W)) u_chk (.*);

// File: tb/test_resv_monitor.sv
module test_resv_monitor;
  localparam int CLK_NS = 10;
  localparam int NC     = 4;
  localparam int NE     = 3;
  localparam int AW     = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_vld;
  logic [1:0]    req_ctx;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_op;
  logic          store_ok, sc_pass, alloc_full;
  logic [NC-1:0] clr_excl;

  int total = 0;
  int bad   = 0;

  // reference model: one reservation per context
  bit        mv [NC];
  bit [25:0] mg [NC];
  int        cnt = 0;

  always #(CLK_NS/2) clk = ~clk;

  resv_monitor #(.N_CTX(NC), .N_ENT(NE), .ADDR_W(AW), .GRAN_LG(6)) i_resv_monitor (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_ctx(req_ctx),
    .req_addr(req_addr), .req_op(req_op), .store_ok(store_ok),
    .sc_pass(sc_pass), .clr_excl(clr_excl), .alloc_full(alloc_full)
  );

  task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s {ok,pass,full,clr} act=%b exp=%b", tag, act, exp);
    end
  endtask

  // expected verdict, updating the model as the requirements say
  function automatic logic [6:0] predict(input int c, input logic [AW-1:0] a, input int op);
    bit [25:0]   g    = a[AW-1:6];
    bit          ok   = 0, ps = 0, fl = 0, wipe = 0;
    bit [NC-1:0] cl   = '0;
    if (op == 1) begin
      if (mv[c]) mg[c] = g;
      else if (cnt < NE) begin mv[c] = 1; mg[c] = g; cnt++; end
      else fl = 1;
    end else if (op == 2) begin
      if (mv[c] && mg[c] == g) begin ok = 1; ps = 1; wipe = 1; end
    end else if (op == 3) begin
      ok = 1; wipe = 1;
    end
    if (wipe) begin
      for (int k = 0; k < NC; k++) begin
        if (mv[k] && mg[k] == g) begin
          mv[k] = 0; cnt--;
          if (k != c) cl[k] = 1;
        end
      end
    end
    return {ok, ps, fl, cl};
  endfunction

  task automatic req(input string tag, input int c, input logic [AW-1:0] a, input int op);
    logic [6:0] e;
    @(negedge clk);
    req_vld = 1'b1; req_ctx = 2'(c); req_addr = a; req_op = 2'(op);
    e = predict(c, a, op);
    @(negedge clk);
    req_vld = 1'b0;
    check(tag, {store_ok, sc_pass, alloc_full, clr_excl}, e);
  endtask

  localparam logic [AW-1:0] GA = 32'h0000_1000;
  localparam logic [AW-1:0] GB = 32'h0000_2040;
  localparam logic [AW-1:0] GC = 32'h0000_3080;

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; req_vld = 1'b0; req_ctx = '0; req_addr = '0; req_op = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 reset", {store_ok, sc_pass, alloc_full, clr_excl}, 7'b0);
    req("R12 empty table sc", 0, GA, 2);
    req("R6 sc without reservation", 0, GA, 2);
    req("R3 ll alloc", 0, GA, 1);
    req("R1 sc other low bits", 0, GA + 32'h3F, 2);
    req("R7 reservation consumed", 0, GA, 2);
    req("R3 ll c0", 0, GA, 1);
    req("R3 ll c1", 1, GA, 1);
    req("R3 ll c2", 2, GA, 1);
    req("R11 sc c1 among others", 1, GA, 2);
    req("R8 c0 wiped", 0, GA, 2);
    req("R2 ll c0 a", 0, GA, 1);
    req("R2 ll c0 overwrite", 0, GB, 1);
    req("R2 sc old granule fails", 0, GA, 2);
    req("R2 sc new granule", 0, GB, 2);
    req("R3 ll c1", 1, GA, 1);
    req("R6 sc c0 no entry", 0, GA, 2);
    req("R6 c1 entry kept", 1, GA, 2);
    req("R3 fill c0", 0, GA, 1);
    req("R3 fill c1", 1, GB, 1);
    req("R3 fill c2", 2, GC, 1);
    req("R10 table full", 3, GA + 32'h100, 1);
    req("R10 c3 no entry", 3, GA + 32'h100, 2);
    req("R4 plain store c3", 3, GA + 32'h8, 3);
    req("R8 clr after store", 1, GB, 3);
    req("R3 alloc after free", 3, GC, 1);
    req("R7 store wipes two", 0, GC + 32'h1, 3);
    // idle strobe with a live op code
    @(negedge clk);
    req_vld = 1'b0; req_op = 2'd3; req_addr = GA;
    @(negedge clk);
    check("R9 idle", {store_ok, sc_pass, alloc_full, clr_excl}, 7'b0);
    for (int n = 0; n < 3000; n++) begin
      int          c  = int'($urandom_range(0, NC - 1));
      int          op = int'($urandom_range(1, 3));
      logic [AW-1:0] a = {22'h0, 4'($urandom_range(0, 3)), 6'($urandom)};
      req(op == 1 ? "R3 random ll" : (op == 2 ? "R5 random sc" : "R4 random st"), c, a, op);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule